// File: doc/BRIEF.md
# DRAM Bank Open-State Tracker

This block follows the command stream that a DRAM memory controller sends out and keeps, for each bank, a record of whether a row is open in it. It also keeps a short per-bank timer that runs after the bank closes. Each cycle it takes a decoded command code, a bank index and one mode address bit. The mode bit has two uses. On a precharge it selects between closing the addressed bank and closing every bank. On a read or write it requests an automatic close of the addressed bank once the access is done.

The controller uses the outputs to schedule commands and to catch sequencing faults. The first output is a per-bank open vector. The second is a flag that is high only when no bank is open and every bank has finished its precharge recovery. The third is a one-cycle error pulse for any command that the current bank state does not allow. An illegal command changes no state. All state updates take effect on the clock edge that captures the command, and the error pulse appears in the cycle after that command.

Top module: `bank_state_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves every bank closed with no recovery pending: `bank_open` is all zero, `all_idle` is 1 and `cmd_err` is 0 from the next cycle on.
- R2: Command codes are NOP=0, ACT=1, RD=2, WR=3 and PRE=4. An ACT to a bank that is closed and recovered sets bit `bank` of `bank_open` in the cycle after the command.
- R3: A PRE with `ap_all`=0 closes only the bank selected by `bank` and starts its recovery. A PRE with `ap_all`=0 to a bank that is already closed changes no state and raises no error.
- R4: A PRE with `ap_all`=1 closes every open bank and starts recovery on each bank it closes. The `bank` field has no effect on the result.
- R5: An RD or WR to an open bank raises no error. With `ap_all`=0 the bank stays open. With `ap_all`=1 the bank closes after the access and starts its recovery.
- R6: An RD or WR to a closed bank makes `cmd_err` high for exactly one cycle, in the cycle after the command, and leaves `bank_open` unchanged.
- R7: An ACT to a bank that is already open, or to a closed bank still in recovery, makes `cmd_err` high for one cycle and leaves `bank_open` unchanged.
- R8: Suppose a bank is closed by a command issued in cycle c. An ACT to that bank is then accepted if it is issued in cycle c+T_RECOV or later, and is rejected if it comes earlier.
- R9: `all_idle` is 1 exactly when no bank is open and no bank is in recovery.
- R10: Command codes 5, 6 and 7 act as NOP. They change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Decoded command code (see R2, R10) |
| bank | input | BANK_AW (3) | Target bank index |
| ap_all | input | 1 | Mode bit: all-bank precharge or auto-close on read/write |
| bank_open | output | NUM_BANKS (8) | Bit i high while bank i is open |
| all_idle | output | 1 | All banks closed and fully recovered |
| cmd_err | output | 1 | One-cycle pulse after an illegal command |

## Verification
A directed sequence first opens two banks and then targets one of them with single-bank precharges. This tells a correct bank-select decode apart from one that closes the wrong bank or every bank. An all-bank precharge is sent with its bank field pointing at an idle bank, which exposes any path where the field still steers the all-bank form. Activates are issued one cycle early and then exactly on time after a close, which brings out an off-by-one in the recovery timer. After that, a long random mix of all eight codes, both mode-bit values, random banks and occasional resets is compared every cycle against a behavioural model. This catches wrong interactions between back-to-back closes, reopens and counter reloads.

// File: rtl/bst_pkg.sv
package bst_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } bst_cmd_e;

endpackage

// File: rtl/bst_cmd_decode.sv
module bst_cmd_decode
   import bst_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int BANK_AW   = 3
) (
   input  logic [2:0]           cmd_code,
   input  logic [BANK_AW-1:0]   bank_sel,
   input  logic                 mode_bit,
   input  logic [NUM_BANKS-1:0] open_vec,
   input  logic [NUM_BANKS-1:0] busy_vec,
   output logic [NUM_BANKS-1:0] open_req,
   output logic [NUM_BANKS-1:0] close_req,
   output logic                 illegal
);

   logic [NUM_BANKS-1:0] sel_1h;
   logic                 tgt_open;
   logic                 tgt_busy;

   always_comb begin
      sel_1h           = '0;
      sel_1h[bank_sel] = 1'b1;
   end

   assign tgt_open = |(sel_1h & open_vec);
   assign tgt_busy = |(sel_1h & busy_vec);

   always_comb begin
      open_req  = '0;
      close_req = '0;
      illegal   = 1'b0;
      case (cmd_code)
         CMD_ACT: begin
            if (tgt_open || tgt_busy) illegal  = 1'b1;
            else                      open_req = sel_1h;
         end
         CMD_RD, CMD_WR: begin
            if (!tgt_open)     illegal   = 1'b1;
            else if (mode_bit) close_req = sel_1h;
         end
         CMD_PRE: begin
            if (mode_bit) close_req = open_vec;
            else          close_req = sel_1h & open_vec;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bst_bank_slot.sv
module bst_bank_slot #(
   parameter int T_RECOV = 5,
   parameter int CNT_W   = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic open_req,
   input  logic close_req,
   output logic is_open,
   output logic busy
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (rst)            open_q <= 1'b0;
      else if (close_req) open_q <= 1'b0;
      else if (open_req)  open_q <= 1'b1;
   end

   assign is_open = open_q;

   // R3
   close_only_open_chk: assert property (@(posedge clk) disable iff (rst)
      close_req |-> open_q);

   generate
      if (T_RECOV <= 1) begin : g_no_timer
         assign busy = 1'b0;
      end else begin : g_timer
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(T_RECOV - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)               cnt_q <= '0;
            else if (close_req)    cnt_q <= LOAD;
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end

         assign busy = (cnt_q != '0);

         // R8
         open_recov_excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(open_q && busy));
         // R8
         timer_load_chk: assert property (@(posedge clk) disable iff (rst)
            close_req |=> (cnt_q == LOAD));
         // R8
         timer_step_chk: assert property (@(posedge clk) disable iff (rst)
            (busy && !close_req) |=> (cnt_q == $past(cnt_q) - 1'b1));
      end
   endgenerate

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
   import bst_pkg::*;
#(
   parameter  int NUM_BANKS = 8,
   parameter  int T_RECOV   = 5,
   localparam int BANK_AW   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2:0]           cmd,
   input  logic [BANK_AW-1:0]   bank,
   input  logic                 ap_all,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic                 all_idle,
   output logic                 cmd_err
);

   localparam int CNT_W = (T_RECOV > 1) ? $clog2(T_RECOV) : 1;

   generate
      if (NUM_BANKS < 2 || (1 << BANK_AW) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (T_RECOV < 1) begin : g_bad_recov
         $error("T_RECOV must be at least 1");
      end
   endgenerate

   logic [NUM_BANKS-1:0] open_vec;
   logic [NUM_BANKS-1:0] busy_vec;
   logic [NUM_BANKS-1:0] open_req;
   logic [NUM_BANKS-1:0] close_req;
   logic                 illegal;
   logic                 err_q;

   bst_cmd_decode #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_AW   (BANK_AW)
   ) u_decode (
      .cmd_code  (cmd),
      .bank_sel  (bank),
      .mode_bit  (ap_all),
      .open_vec  (open_vec),
      .busy_vec  (busy_vec),
      .open_req  (open_req),
      .close_req (close_req),
      .illegal   (illegal)
   );

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_slot
         bst_bank_slot #(
            .T_RECOV (T_RECOV),
            .CNT_W   (CNT_W)
         ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .open_req  (open_req[i]),
            .close_req (close_req[i]),
            .is_open   (open_vec[i]),
            .busy      (busy_vec[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= illegal;
   end

   assign bank_open = open_vec;
   assign all_idle  = ~|open_vec && ~|busy_vec;
   assign cmd_err   = err_q;

   // R6
   err_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      illegal |=> (bank_open == $past(bank_open)));
   // R4
   pre_all_close_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_PRE && ap_all) |=> (bank_open == '0));
   // R2
   act_opens_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_ACT && !open_vec[bank] && !busy_vec[bank]) |=> bank_open[$past(bank)]);
   // R10
   reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd > 3'd4) |=> (bank_open == $past(bank_open) && !cmd_err));

endmodule

// File: tb/tb_bank_state_tracker.sv
module tb_bank_state_tracker;

   localparam int NB = 8;
   localparam int TR = 5;

   logic          clk = 1'b0;
   logic          rst;
   logic [2:0]    cmd;
   logic [2:0]    bank;
   logic          ap_all;
   logic [NB-1:0] bank_open;
   logic          all_idle;
   logic          cmd_err;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 0;

   int  m_open [NB];
   int  m_cnt  [NB];
   bit  m_err;

   always #5 clk = ~clk;

   bank_state_tracker #(.NUM_BANKS(NB), .T_RECOV(TR)) dut (
      .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .ap_all(ap_all),
      .bank_open(bank_open), .all_idle(all_idle), .cmd_err(cmd_err)
   );

   function automatic void model_reset();
      for (int i = 0; i < NB; i++) begin
         m_open[i] = 0;
         m_cnt[i]  = 0;
      end
      m_err = 0;
   endfunction

   function automatic void model_tick(int c, int b, bit a);
      bit cl [NB];
      bit op [NB];
      bit e = 0;
      for (int i = 0; i < NB; i++) begin
         cl[i] = 0;
         op[i] = 0;
      end
      if (c == 1) begin
         if (m_open[b] != 0 || m_cnt[b] != 0) e = 1;
         else op[b] = 1;
      end else if (c == 2 || c == 3) begin
         if (m_open[b] == 0) e = 1;
         else if (a) cl[b] = 1;
      end else if (c == 4) begin
         for (int i = 0; i < NB; i++)
            if (m_open[i] != 0 && (a || i == b)) cl[i] = 1;
      end
      for (int i = 0; i < NB; i++) begin
         if (cl[i]) begin
            m_open[i] = 0;
            m_cnt[i]  = TR - 1;
         end else if (op[i]) begin
            m_open[i] = 1;
         end else if (m_cnt[i] > 0) begin
            m_cnt[i]--;
         end
      end
      m_err = e;
   endfunction

   task automatic compare(string tag);
      logic [NB-1:0] e_open;
      bit e_idle = 1;
      for (int i = 0; i < NB; i++) begin
         e_open[i] = (m_open[i] != 0);
         if (m_open[i] != 0 || m_cnt[i] != 0) e_idle = 0;
      end
      n_cmp++;
      if (bank_open !== e_open) begin
         n_fail++;
         $display("FAIL %s bank_open actual=%b expected=%b", tag, bank_open, e_open);
      end
      n_cmp++;
      if (all_idle !== e_idle) begin
         n_fail++;
         $display("FAIL %s all_idle actual=%b expected=%b", tag, all_idle, e_idle);
      end
      n_cmp++;
      if (cmd_err !== m_err) begin
         n_fail++;
         $display("FAIL %s cmd_err actual=%b expected=%b", tag, cmd_err, m_err);
      end
   endtask

   task automatic step(int c, int b, bit a, string tag);
      cmd    = c[2:0];
      bank   = b[2:0];
      ap_all = a;
      @(posedge clk);
      model_tick(c, b, a);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset(string tag);
      rst = 1'b1;
      cmd = 3'd0;
      @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 1'b0;
      compare(tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; cmd = 3'd0; bank = 3'd0; ap_all = 1'b0;
      model_reset();
      @(negedge clk);
      do_reset("R1 reset");
      step(0, 0, 0, "R1 idle after reset");
      // R2 opens
      step(1, 2, 0, "R2 act bank2");
      step(1, 5, 0, "R2 act bank5");
      // R5 accesses without close
      step(2, 2, 0, "R5 rd bank2");
      step(3, 5, 0, "R5 wr bank5");
      // R7 reopen, R6 access to closed bank
      step(1, 2, 0, "R7 act open bank");
      step(2, 3, 0, "R6 rd closed bank");
      step(0, 0, 0, "R6 pulse ends");
      // R3 single precharge and repeat on idle bank
      step(4, 2, 0, "R3 pre bank2");
      step(4, 2, 0, "R3 pre idle bank");
      // R8 early and on-time activates
      step(1, 2, 0, "R8 act too early");
      step(6, 2, 1, "R10 code6");
      step(1, 2, 0, "R8 act one early");
      step(1, 2, 0, "R8 act on time");
      step(7, 0, 0, "R10 code7");
      step(5, 3, 1, "R10 code5");
      // R4 all-bank precharge with bank field at an idle bank
      step(4, 7, 1, "R4 pre all");
      for (int k = 0; k < TR; k++) step(0, 0, 0, "R9 wait idle");
      // R5 auto-close, then R7 act during recovery
      step(1, 0, 0, "R2 act bank0");
      step(3, 0, 1, "R5 wr auto close");
      step(1, 0, 0, "R7 act in recovery");
      for (int k = 0; k < 2000; k++) begin
         int r  = $urandom_range(0, 99);
         int c  = (r < 30) ? 1 : (r < 50) ? 2 : (r < 65) ? 3 : (r < 85) ? 4 : $urandom_range(0, 7);
         int b  = $urandom_range(0, NB - 1);
         bit a  = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 299) == 0) do_reset("R1 random reset");
         else step(c, b, a, "R9 random mix");
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule